// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block sits next to a UART transmitter and its receive FIFO. It takes care of hardware handshaking in both directions and watches the receive stream for one chosen character. The host programs an 8-bit feature register. From that register the block derives four things: a transmit permit driven by the synchronized clear-to-send input, a request-to-send output with hysteresis on the FIFO fill level, a sticky flag that marks a received special character, and write masks that lock the enhanced fields of three neighbouring registers.

Every feature bit comes out of reset cleared. The four low bits of the register choose a software handshake mode. This block only stores and returns them; the logic that acts on them lives elsewhere. The transmitter reports through `tx_busy` when a character is on the line. A stop request is held back until that character is finished.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset the feature register reads 0x00, `tx_permit` is 1, `rts_n` is 1 and `spc_flag` is 0.
- R2: A write through `feat_wr_en` stores all 8 bits of `feat_wr_data`, and `feat_rd_data` shows them from the next cycle. This includes the mode bits [3:0], which have no other effect.
- R3: With feature bit 7 set and `tx_busy` low, `tx_permit` drops to 0 on the third rising edge after `cts_n` goes to 1. Two of those edges belong to the synchronizer. `tx_permit` rises back to 1 on the third edge after `cts_n` returns to 0.
- R4: On any edge where `tx_busy` is 1, `tx_permit` keeps its value. A pending stop or resume is applied on the first edge with `tx_busy` low.
- R5: With feature bit 7 clear, `tx_permit` is 1 after every edge with `tx_busy` low, whatever `cts_n` does.
- R6: With feature bit 6 set, `rts_n` becomes 1 on the edge after `rx_level` exceeds `thr_hi`. It becomes 0 on the edge after `rx_level` is below `thr_lo`. It holds its value when `thr_lo <= rx_level <= thr_hi`. Only `thr_hi > thr_lo` is supported.
- R7: With feature bit 6 clear, `rts_n` equals the inverse of `mcr_rts` as sampled on the previous edge.
- R8: With feature bit 5 set, an `rx_strobe` whose `rx_data` equals `xoff2_val` sets `spc_flag` on that edge. Mismatching characters, edges without a strobe, and any character while bit 5 is clear leave the flag unchanged.
- R9: `isr_rd` clears `spc_flag` on its edge. A match on the same edge wins, and the flag stays 1.
- R10: With feature bit 4 clear, the masks read `ier_wr_mask` = 0x0F, `fcr_wr_mask` = 0xCF and `mcr_wr_mask` = 0x1F. With it set, all three read 0xFF. A mask bit of 1 means the neighbouring register accepts a write to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_wr_en | input | 1 | Feature register write strobe |
| feat_wr_data | input | 8 | Feature register write data |
| feat_rd_data | output | 8 | Feature register contents |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_permit | output | 1 | Transmitter may start a new character |
| rx_level | input | 8 | Receive FIFO fill level |
| thr_hi | input | 8 | Upper RTS threshold |
| thr_lo | input | 8 | Lower RTS threshold |
| mcr_rts | input | 1 | Host RTS request, used when automatic RTS is off |
| rts_n | output | 1 | Request-to-send, active low |
| xoff2_val | input | 8 | Special character compare value |
| rx_strobe | input | 1 | A received character is valid |
| rx_data | input | 8 | Received character |
| isr_rd | input | 1 | Host reads interrupt status (clears flag) |
| spc_flag | output | 1 | Special character seen |
| ier_wr_mask | output | 8 | Writable bits of the interrupt enable register |
| fcr_wr_mask | output | 8 | Writable bits of the FIFO control register |
| mcr_wr_mask | output | 8 | Writable bits of the modem control register |

## Verification
Two collisions matter here, and the bench provokes both. The first is a special-character match on the same edge as a host status read. The random phase raises `rx_strobe` carrying the compare value and `isr_rd` together often. A bench model that lets set override clear predicts the flag after each such edge. The second is a clear-to-send change that arrives while `tx_busy` is high. Directed steps hold `tx_busy` for several cycles after the synchronizer has settled. The bench checks that `tx_permit` does not move until the first idle edge, and that it moves on exactly that edge.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned DW = 8;

  typedef struct packed {
    logic          cts_auto;
    logic          rts_auto;
    logic          spc_en;
    logic          enh_unlock;
    logic [3:0]    sw_mode;
  } feat_t;

  // Next request-to-send level (1 = stop the far end) under hysteresis.
  function automatic logic rts_next(input logic [DW-1:0] lvl,
                                    input logic [DW-1:0] hi,
                                    input logic [DW-1:0] lo,
                                    input logic          prev);
    if (lvl > hi)      return 1'b1;
    else if (lvl < lo) return 1'b0;
    else               return prev;
  endfunction

  // Write mask for a register whose enhanced field is [top:bot].
  function automatic logic [DW-1:0] lock_mask(input logic unlock,
                                              input int unsigned top,
                                              input int unsigned bot);
    logic [DW-1:0] m;
    m = '1;
    if (!unlock)
      for (int unsigned i = 0; i < DW; i++)
        if (i >= bot && i <= top) m[i] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/afc_cts_gate.sv
module afc_cts_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cts_n,
  input  logic tx_busy,
  output logic stop_req,
  output logic tx_permit
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n};
  end

  assign stop_req = enable & sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_permit <= 1'b1;
    else if (!tx_busy) tx_permit <= ~stop_req;
  end
endmodule

// File: rtl/afc_rts_hyst.sv
module afc_rts_hyst
  import afc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [DW-1:0] level,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic          manual_rts,
  output logic          rts_n
);
  logic auto_val;
  assign auto_val = rts_next(level, thr_hi, thr_lo, rts_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b1;
    else        rts_n <= enable ? auto_val : ~manual_rts;
  end
endmodule

// File: rtl/afc_char_match.sv
module afc_char_match
  import afc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          strobe,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] cmp,
  input  logic          clr,
  output logic          hit,
  output logic          flag
);
  assign hit = enable & strobe & (data == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import afc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          feat_wr_en,
  input  logic [DW-1:0] feat_wr_data,
  output logic [DW-1:0] feat_rd_data,
  input  logic          cts_n,
  input  logic          tx_busy,
  output logic          tx_permit,
  input  logic [DW-1:0] rx_level,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic          mcr_rts,
  output logic          rts_n,
  input  logic [DW-1:0] xoff2_val,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_data,
  input  logic          isr_rd,
  output logic          spc_flag,
  output logic [DW-1:0] ier_wr_mask,
  output logic [DW-1:0] fcr_wr_mask,
  output logic [DW-1:0] mcr_wr_mask
);
  feat_t feat_q;
  logic  cts_stop_req;
  logic  spc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          feat_q <= '0;
    else if (feat_wr_en) feat_q <= feat_t'(feat_wr_data);
  end

  assign feat_rd_data = feat_q;

  afc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .enable(feat_q.cts_auto), .cts_n(cts_n),
    .tx_busy(tx_busy), .stop_req(cts_stop_req), .tx_permit(tx_permit)
  );

  afc_rts_hyst u_rts (
    .clk(clk), .rst_n(rst_n), .enable(feat_q.rts_auto), .level(rx_level),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .manual_rts(mcr_rts), .rts_n(rts_n)
  );

  afc_char_match u_spc (
    .clk(clk), .rst_n(rst_n), .enable(feat_q.spc_en), .strobe(rx_strobe),
    .data(rx_data), .cmp(xoff2_val), .clr(isr_rd), .hit(spc_hit),
    .flag(spc_flag)
  );

  assign ier_wr_mask = lock_mask(feat_q.enh_unlock, 7, 4);
  assign fcr_wr_mask = lock_mask(feat_q.enh_unlock, 5, 4);
  assign mcr_wr_mask = lock_mask(feat_q.enh_unlock, 7, 5);
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] feat_rd_data,
  input logic       tx_busy,
  input logic       tx_permit,
  input logic [7:0] rx_level,
  input logic [7:0] thr_hi,
  input logic [7:0] thr_lo,
  input logic       mcr_rts,
  input logic       rts_n,
  input logic [7:0] xoff2_val,
  input logic       rx_strobe,
  input logic [7:0] rx_data,
  input logic       isr_rd,
  input logic       spc_flag,
  input logic       spc_hit
);
  logic match_in;
  assign match_in = feat_rd_data[5] && rx_strobe && (rx_data == xoff2_val);

  AST_PERMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> $stable(tx_permit)); // R4
  AST_CTS_OFF_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!feat_rd_data[7] && !tx_busy) |=> tx_permit); // R5
  AST_RTS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_rd_data[6] && rx_level > thr_hi) |=> rts_n); // R6
  AST_RTS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_rd_data[6] && rx_level < thr_lo) |=> !rts_n); // R6
  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_rd_data[6] |=> (rts_n == !$past(mcr_rts))); // R7
  AST_SPC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match_in |=> spc_flag); // R8
  AST_SPC_HIT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    spc_hit == match_in); // R8
  AST_SPC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !match_in) |=> !spc_flag); // R9
endmodule

bind uart_flow_ctl uart_flow_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .feat_rd_data(feat_rd_data), .tx_busy(tx_busy),
  .tx_permit(tx_permit), .rx_level(rx_level), .thr_hi(thr_hi),
  .thr_lo(thr_lo), .mcr_rts(mcr_rts), .rts_n(rts_n), .xoff2_val(xoff2_val),
  .rx_strobe(rx_strobe), .rx_data(rx_data), .isr_rd(isr_rd),
  .spc_flag(spc_flag), .spc_hit(spc_hit)
);

// File: tb/uart_flow_ctl_tb_top.sv
module uart_flow_ctl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       feat_wr_en = 1'b0;
  logic [7:0] feat_wr_data = '0;
  logic [7:0] feat_rd_data;
  logic       cts_n = 1'b0;
  logic       tx_busy = 1'b0;
  logic       tx_permit;
  logic [7:0] rx_level = '0;
  logic [7:0] thr_hi = 8'hC0;
  logic [7:0] thr_lo = 8'h40;
  logic       mcr_rts = 1'b0;
  logic       rts_n;
  logic [7:0] xoff2_val = 8'h13;
  logic       rx_strobe = 1'b0;
  logic [7:0] rx_data = '0;
  logic       isr_rd = 1'b0;
  logic       spc_flag;
  logic [7:0] ier_wr_mask, fcr_wr_mask, mcr_wr_mask;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flow_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .feat_wr_en(feat_wr_en),
    .feat_wr_data(feat_wr_data), .feat_rd_data(feat_rd_data), .cts_n(cts_n),
    .tx_busy(tx_busy), .tx_permit(tx_permit), .rx_level(rx_level),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .mcr_rts(mcr_rts), .rts_n(rts_n),
    .xoff2_val(xoff2_val), .rx_strobe(rx_strobe), .rx_data(rx_data),
    .isr_rd(isr_rd), .spc_flag(spc_flag), .ier_wr_mask(ier_wr_mask),
    .fcr_wr_mask(fcr_wr_mask), .mcr_wr_mask(mcr_wr_mask)
  );

  function automatic logic exp_rts(logic [7:0] lvl, logic [7:0] hi,
                                   logic [7:0] lo, logic prev);
    if (lo > lvl) return 1'b0;
    if (hi < lvl) return 1'b1;
    return prev;
  endfunction

  function automatic logic [7:0] exp_mask(logic unlocked, logic [7:0] locked_val);
    return unlocked ? 8'hFF : locked_val;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_feat(logic [7:0] v);
    feat_wr_en = 1'b1;
    feat_wr_data = v;
    tick();
    feat_wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic model_rts;
    logic model_flag;
    void'($urandom(32'd2024));
    #(CLK_PERIOD * 2);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 feat", feat_rd_data, 8'h00);
    check("R1 permit", tx_permit, 1'b1);
    check("R1 rts", rts_n, 1'b1);
    check("R1 flag", spc_flag, 1'b0);

    // R10 locked masks
    check("R10 ier locked", ier_wr_mask, exp_mask(1'b0, 8'h0F));
    check("R10 fcr locked", fcr_wr_mask, exp_mask(1'b0, 8'hCF));
    check("R10 mcr locked", mcr_wr_mask, exp_mask(1'b0, 8'h1F));

    // R2 write/readback incl. mode bits
    write_feat(8'h1A);
    check("R2 readback", feat_rd_data, 8'h1A);
    check("R10 ier open", ier_wr_mask, exp_mask(1'b1, 8'h0F));
    check("R10 fcr open", fcr_wr_mask, exp_mask(1'b1, 8'hCF));
    check("R10 mcr open", mcr_wr_mask, exp_mask(1'b1, 8'h1F));
    write_feat(8'h05);
    check("R2 readback low", feat_rd_data, 8'h05);
    check("R10 relock ier", ier_wr_mask, 8'h0F);

    // R5 CTS ignored while auto-CTS off
    cts_n = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    check("R5 permit cts off", tx_permit, 1'b1);
    cts_n = 1'b0;
    for (int i = 0; i < 3; i++) tick();

    // R3 stop/resume timing
    write_feat(8'h80);
    cts_n = 1'b1;
    tick(); tick();
    check("R3 permit after 2 edges", tx_permit, 1'b1);
    tick();
    check("R3 permit stopped", tx_permit, 1'b0);
    cts_n = 1'b0;
    tick(); tick();
    check("R3 still stopped", tx_permit, 1'b0);
    tick();
    check("R3 resumed", tx_permit, 1'b1);

    // R4 boundary hold
    tx_busy = 1'b1;
    cts_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    check("R4 hold while busy", tx_permit, 1'b1);
    tx_busy = 1'b0;
    tick();
    check("R4 stop at boundary", tx_permit, 1'b0);
    tx_busy = 1'b1;
    cts_n = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check("R4 resume held", tx_permit, 1'b0);
    tx_busy = 1'b0;
    tick();
    check("R4 resume at boundary", tx_permit, 1'b1);

    // R7 manual RTS
    write_feat(8'h00);
    mcr_rts = 1'b1;
    tick();
    check("R7 manual assert", rts_n, 1'b0);
    mcr_rts = 1'b0;
    tick();
    check("R7 manual release", rts_n, 1'b1);
    mcr_rts = 1'b1;
    tick();
    model_rts = 1'b0;

    // R6 directed hysteresis sweep
    write_feat(8'h40);
    model_rts = exp_rts(rx_level, thr_hi, thr_lo, model_rts);
    check("R6 after enable", rts_n, model_rts);
    foreach (thr_hi[i]) begin end
    rx_level = 8'h40; tick(); check("R6 at lo holds", rts_n, 1'b0);
    rx_level = 8'hC0; tick(); check("R6 at hi holds", rts_n, 1'b0);
    rx_level = 8'hC1; tick(); check("R6 above hi", rts_n, 1'b1);
    rx_level = 8'h80; tick(); check("R6 between holds high", rts_n, 1'b1);
    rx_level = 8'h40; tick(); check("R6 at lo holds high", rts_n, 1'b1);
    rx_level = 8'h3F; tick(); check("R6 below lo", rts_n, 1'b0);
    model_rts = 1'b0;

    // R6 random
    for (int i = 0; i < 400; i++) begin
      rx_level = 8'($urandom_range(0, 255));
      mcr_rts = 1'($urandom);
      @(posedge clk);
      model_rts = exp_rts(rx_level, thr_hi, thr_lo, model_rts);
      @(negedge clk);
      check("R6 random", rts_n, model_rts);
    end

    // R8 disabled: match ignored
    write_feat(8'h00);
    rx_strobe = 1'b1; rx_data = 8'h13; tick(); rx_strobe = 1'b0;
    check("R8 disabled no flag", spc_flag, 1'b0);

    write_feat(8'h20);
    rx_strobe = 1'b1; rx_data = 8'h14; tick(); rx_strobe = 1'b0;
    check("R8 mismatch no flag", spc_flag, 1'b0);
    rx_data = 8'h13; tick();
    check("R8 no strobe no flag", spc_flag, 1'b0);
    rx_strobe = 1'b1; tick(); rx_strobe = 1'b0;
    check("R8 match sets", spc_flag, 1'b1);
    tick();
    check("R9 sticky", spc_flag, 1'b1);
    isr_rd = 1'b1; rx_strobe = 1'b1; tick();
    check("R9 match beats read", spc_flag, 1'b1);
    rx_strobe = 1'b0; tick(); isr_rd = 1'b0;
    check("R9 read clears", spc_flag, 1'b0);
    model_flag = 1'b0;

    // R8/R9 random collisions
    for (int i = 0; i < 400; i++) begin
      rx_strobe = 1'($urandom);
      rx_data = ($urandom_range(0, 2) == 0) ? 8'h13 : 8'($urandom);
      isr_rd = ($urandom_range(0, 3) == 0);
      @(posedge clk);
      if (rx_strobe && rx_data == xoff2_val) model_flag = 1'b1;
      else if (isr_rd) model_flag = 1'b0;
      @(negedge clk);
      check("R9 random flag", spc_flag, model_flag);
    end
    rx_strobe = 1'b0;
    isr_rd = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule